// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical address using a small table of block mapping entries, without walking any page table. Two independent tables exist: one consulted for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words. The descriptor word holds the effective region base, a region-size mask and two privilege enables. The target word holds the physical region base and a two-bit permission code.

A lookup is purely combinational from the stored entries. In the cycle the inputs are presented, the block returns a hit flag, the translated address and read/write permission. Entries are loaded through a synchronous write port. When translation is switched off for the access, the page-aligned address is returned unchanged with full permission. When no entry matches, the block reports a miss and nothing else, so a surrounding unit can fall back to another translation path.

Top module: `blkmap_xlate`

## Requirements
- R1: `lk_ifetch`=1 consults only the instruction table (`wr_side`=1) and `lk_ifetch`=0 consults only the data table (`wr_side`=0). An entry in one table never produces a hit for the other kind of access.
- R2: Descriptor bits 31:28 must equal address bits 31:28 exactly. Descriptor bits 12:2 form a size mask over address bits 27:17. Address bits 27:17 with the masked positions forced to zero must equal descriptor bits 27:17.
- R3: Descriptor bit 1 enables the entry for supervisor accesses (`lk_user`=0). Descriptor bit 0 enables it for user accesses (`lk_user`=1). An address match without the enable for the current privilege is not a hit.
- R4: On a hit, the output address is built as follows: bits 31:28 come from target bits 31:28; bits 27:17 are target bits 27:17 ORed with the address bits at masked positions; bits 16:0 are the address bits 16:0 unchanged (page bits 16:12 and offset 11:0).
- R5: Target bit 1 set grants read and write. Bit 1 clear with bit 0 set grants read only. Both clear grants neither, and the access is still reported as a hit.
- R6: When several entries of the selected table hit, the entry with the lowest index supplies the address and the permission.
- R7: With `lk_xlate_on`=0, the outputs are hit=1, read=1, write=1 and an address equal to the input address with bits 11:0 cleared, whatever the table holds.
- R8: With translation on and no hitting entry, hit, read and write are 0 and the output address is 0.
- R9: A write through the port becomes visible to lookups starting at the clock edge that captures it, and not before. Reset clears every word, so every translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all entries |
| wr_en | input | 1 | Write strobe for the entry port |
| wr_side | input | 1 | Table to write: 1 instruction, 0 data |
| wr_idx | input | 2 | Entry index within the table |
| wr_hi | input | 1 | 1 writes the descriptor word, 0 the target word |
| wr_data | input | 32 | Word to store |
| lk_ifetch | input | 1 | Access kind: 1 instruction fetch, 0 data |
| lk_xlate_on | input | 1 | Translation enabled for this access |
| lk_user | input | 1 | Privilege: 1 user, 0 supervisor |
| lk_addr | input | 32 | Effective address |
| hit | output | 1 | Entry matched, or translation off |
| phys_addr | output | 32 | Translated address |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |

## Verification
A wrong stored word or a corrupted enable shows up at once: the hit flag or the address is wrong in the same cycle as a lookup that covers that entry. A faulty priority choice shows only when two entries overlap, so the bench builds overlapping regions on purpose and then disables the winner to expose the runner-up. A write that lands a cycle late or early is caught by sampling the lookup just before and just after the capturing edge.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

  typedef struct packed {
    logic [3:0]  nib;
    logic [10:0] mid;
    logic [3:0]  rsv;
    logic [10:0] len;
    logic        sup_en;
    logic        usr_en;
  } desc_t;

  typedef struct packed {
    logic [3:0]  nib;
    logic [10:0] mid;
    logic [14:0] rsv;
    logic        rw;
    logic        ro;
  } targ_t;

  function automatic logic f_addr_match(input desc_t d, input logic [31:0] a);
    return (a[31:28] == d.nib) && ((a[27:17] & ~d.len) == d.mid);
  endfunction

  function automatic logic f_priv_ok(input desc_t d, input logic user);
    return user ? d.usr_en : d.sup_en;
  endfunction

  function automatic logic [31:0] f_phys(input desc_t d, input targ_t t,
                                         input logic [31:0] a);
    return {t.nib, (a[27:17] & d.len) | t.mid, a[16:0]};
  endfunction

  function automatic logic [1:0] f_perm(input targ_t t);
    logic [1:0] p;
    if (t.rw)      p = 2'b11;
    else if (t.ro) p = 2'b10;
    else           p = 2'b00;
    return p;
  endfunction

endpackage

// File: rtl/blkmap_regs.sv
module blkmap_regs #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_side,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_hi,
  input  logic [31:0]          wr_data,
  input  logic                 rd_side,
  output blkmap_pkg::desc_t    desc_o [NUM_ENT],
  output blkmap_pkg::targ_t    targ_o [NUM_ENT]
);
  import blkmap_pkg::*;

  localparam int NSIDE = 2;

  logic [31:0] hi_q [NSIDE][NUM_ENT];
  logic [31:0] lo_q [NSIDE][NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSIDE; s++) begin
        for (int e = 0; e < NUM_ENT; e++) begin
          hi_q[s][e] <= '0;
          lo_q[s][e] <= '0;
        end
      end
    end else if (wr_en) begin
      if (wr_hi) hi_q[wr_side][wr_idx] <= wr_data;
      else       lo_q[wr_side][wr_idx] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_sel
      assign desc_o[g] = desc_t'(hi_q[rd_side][g]);
      assign targ_o[g] = targ_t'(lo_q[rd_side][g]);
    end
  endgenerate

  function automatic logic any_enabled();
    logic r;
    r = 1'b0;
    for (int s = 0; s < NSIDE; s++)
      for (int e = 0; e < NUM_ENT; e++)
        r = r | (|hi_q[s][e][1:0]);
    return r;
  endfunction

  // R9: the captured word is stored by the edge that sees the strobe
  a_r9_hi_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_hi |=> hi_q[$past(wr_side)][$past(wr_idx)] == $past(wr_data));
  a_r9_lo_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_hi |=> lo_q[$past(wr_side)][$past(wr_idx)] == $past(wr_data));
  // R9: leaving reset, no entry is enabled
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !any_enabled());

endmodule

// File: rtl/blkmap_cmp.sv
module blkmap_cmp (
  input  blkmap_pkg::desc_t desc_i,
  input  blkmap_pkg::targ_t targ_i,
  input  logic [31:0]       addr_i,
  input  logic              user_i,
  output logic              hit_o,
  output logic [31:0]       phys_o,
  output logic              rd_o,
  output logic              wr_o
);
  import blkmap_pkg::*;

  logic       addr_ok;
  logic       priv_ok;
  logic [1:0] perm;

  assign addr_ok = f_addr_match(desc_i, addr_i);
  assign priv_ok = f_priv_ok(desc_i, user_i);
  assign hit_o   = addr_ok && priv_ok;
  assign phys_o  = f_phys(desc_i, targ_i, addr_i);
  assign perm    = f_perm(targ_i);
  assign rd_o    = perm[1];
  assign wr_o    = perm[0];

endmodule

// File: rtl/blkmap_prio.sv
module blkmap_prio #(
  parameter int NUM_ENT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] req_i,
  output logic [NUM_ENT-1:0] win_o,
  output logic               any_o
);
  logic [NUM_ENT-1:0] below;

  always_comb begin
    below[0] = 1'b0;
    for (int i = 1; i < NUM_ENT; i++) below[i] = below[i-1] | req_i[i-1];
  end

  assign win_o = req_i & ~below;
  assign any_o = |win_o;

  // R6: at most one winner, and no requester sits below it
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_o - 1'b1) & req_i & {NUM_ENT{any_o}}) == '0);
  a_r6_winner_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> $countones(win_o) == 1);

endmodule

// File: rtl/blkmap_xlate.sv
module blkmap_xlate #(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_side,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             lk_ifetch,
  input  logic             lk_xlate_on,
  input  logic             lk_user,
  input  logic [31:0]      lk_addr,
  output logic             hit,
  output logic [31:0]      phys_addr,
  output logic             perm_rd,
  output logic             perm_wr
);
  import blkmap_pkg::*;

  desc_t              desc [NUM_ENT];
  targ_t              targ [NUM_ENT];
  logic [NUM_ENT-1:0] ent_hit;
  logic [NUM_ENT-1:0] ent_rd;
  logic [NUM_ENT-1:0] ent_wr;
  logic [31:0]        ent_phys [NUM_ENT];
  logic [NUM_ENT-1:0] win;
  logic               any_hit;
  logic [31:0]        sel_phys;
  logic               sel_rd;
  logic               sel_wr;

  blkmap_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_side (wr_side),
    .wr_idx  (wr_idx),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .rd_side (lk_ifetch),
    .desc_o  (desc),
    .targ_o  (targ)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_ent
      blkmap_cmp u_cmp (
        .desc_i (desc[g]),
        .targ_i (targ[g]),
        .addr_i (lk_addr),
        .user_i (lk_user),
        .hit_o  (ent_hit[g]),
        .phys_o (ent_phys[g]),
        .rd_o   (ent_rd[g]),
        .wr_o   (ent_wr[g])
      );
    end
  endgenerate

  blkmap_prio #(.NUM_ENT(NUM_ENT)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (ent_hit),
    .win_o (win),
    .any_o (any_hit)
  );

  always_comb begin
    sel_phys = '0;
    sel_rd   = 1'b0;
    sel_wr   = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      sel_phys = sel_phys | (ent_phys[i] & {32{win[i]}});
      sel_rd   = sel_rd | (ent_rd[i] & win[i]);
      sel_wr   = sel_wr | (ent_wr[i] & win[i]);
    end
  end

  always_comb begin
    if (!lk_xlate_on) begin
      hit       = 1'b1;
      phys_addr = {lk_addr[31:12], 12'h000};
      perm_rd   = 1'b1;
      perm_wr   = 1'b1;
    end else begin
      hit       = any_hit;
      phys_addr = sel_phys;
      perm_rd   = sel_rd;
      perm_wr   = sel_wr;
    end
  end

  // R8: a translated miss grants nothing and drives a zero address
  a_r8_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xlate_on && !hit |-> !perm_rd && !perm_wr && phys_addr == '0);
  // R5: write permission never comes without read permission
  a_r5_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    perm_wr |-> perm_rd);
  // R7: untranslated access is page aligned with full rights
  a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_xlate_on |-> hit && perm_rd && perm_wr &&
                     phys_addr == {lk_addr[31:12], 12'h000});
  // R4: low seventeen address bits survive a translated hit
  a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xlate_on && hit |-> phys_addr[16:0] == lk_addr[16:0]);

endmodule

// File: tb/test_blkmap_xlate.sv
module test_blkmap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        lk_ifetch = 1'b0, lk_xlate_on = 1'b1, lk_user = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        hit, perm_rd, perm_wr;
  logic [31:0] phys_addr;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_hi [2][4];
  logic [31:0] m_lo [2][4];

  always #10 clk = ~clk;

  blkmap_xlate i_blkmap_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .lk_ifetch(lk_ifetch), .lk_xlate_on(lk_xlate_on), .lk_user(lk_user),
    .lk_addr(lk_addr), .hit(hit), .phys_addr(phys_addr),
    .perm_rd(perm_rd), .perm_wr(perm_wr)
  );

  // expected {hit, rd, wr, phys} built bit by bit from the requirements
  function automatic logic [34:0] model(input logic f, input logic xon,
                                        input logic u, input logic [31:0] a);
    logic [34:0] r;
    int s;
    r = '0;
    s = f ? 1 : 0;
    if (!xon) return {3'b111, a[31:12], 12'h000};
    for (int e = 3; e >= 0; e--) begin
      logic ok;
      logic [31:0] p;
      logic [31:0] h;
      logic [31:0] l;
      h = m_hi[s][e];
      l = m_lo[s][e];
      ok = (a[31:28] == h[31:28]);
      for (int b = 0; b < 11; b++) begin
        logic mb;
        mb = h[2+b];
        if (!mb && a[17+b] != h[17+b]) ok = 1'b0;
        if (mb && h[17+b]) ok = 1'b0;
        p[17+b] = l[17+b] | (mb & a[17+b]);
      end
      ok = ok && (u ? h[0] : h[1]);
      p[31:28] = l[31:28];
      p[16:0]  = a[16:0];
      if (ok) r = {1'b1, l[1] | l[0], l[1], p};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [34:0] exp);
    logic [34:0] act;
    act = {hit, perm_rd, perm_wr, phys_addr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got hit/rd/wr/addr %b%b%b %h, expected %b%b%b %h", req,
               act[34], act[33], act[32], act[31:0],
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic put(input logic side, input int idx, input logic hi_w,
                     input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_side = side; wr_idx = idx[1:0]; wr_hi = hi_w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (hi_w) m_hi[side][idx] = d; else m_lo[side][idx] = d;
  endtask

  task automatic look(input string req, input logic f, input logic xon,
                      input logic u, input logic [31:0] a);
    @(negedge clk);
    lk_ifetch = f; lk_xlate_on = xon; lk_user = u; lk_addr = a;
    #2;
    check(req, model(f, xon, u, a));
  endtask

  task automatic t_reset;
    look("R9 reset miss", 1'b0, 1'b1, 1'b0, 32'h8001_F345);
    look("R8 reset miss instr", 1'b1, 1'b1, 1'b1, 32'h0000_0000);
    check("R8 miss fields", {3'b000, 32'h0});
  endtask

  task automatic t_write_timing;
    put(1'b0, 0, 1'b0, 32'h2460_0002);
    @(negedge clk);
    wr_en = 1'b1; wr_side = 1'b0; wr_idx = 2'd0; wr_hi = 1'b1;
    wr_data = 32'h8000_0002;
    lk_ifetch = 1'b0; lk_xlate_on = 1'b1; lk_user = 1'b0; lk_addr = 32'h8001_F345;
    #2;
    check("R9 before edge", {3'b000, 32'h0});
    @(negedge clk);
    wr_en = 1'b0;
    m_hi[0][0] = 32'h8000_0002;
    #2;
    check("R9 after edge", {3'b111, 32'h2461_F345});
  endtask

  task automatic t_match;
    look("R2 mid bit outside mask", 1'b0, 1'b1, 1'b0, 32'h8002_0000);
    put(1'b0, 1, 1'b1, 32'h3000_1FFF);
    put(1'b0, 1, 1'b0, 32'h5000_0001);
    look("R2 full mask hit", 1'b0, 1'b1, 1'b0, 32'h3ABC_DEF0);
    check("R4 full mask address", {3'b110, 32'h5ABC_DEF0});
    look("R2 nibble mismatch", 1'b0, 1'b1, 1'b0, 32'h4ABC_DEF0);
  endtask

  task automatic t_priv;
    look("R3 user on supervisor-only", 1'b0, 1'b1, 1'b1, 32'h8001_F345);
    look("R3 user on both-enabled", 1'b0, 1'b1, 1'b1, 32'h3000_0123);
    put(1'b0, 1, 1'b1, 32'h3000_1FFD);
    look("R3 supervisor on user-only", 1'b0, 1'b1, 1'b0, 32'h3000_0123);
  endtask

  task automatic t_partial;
    put(1'b0, 2, 1'b1, 32'hC800_001F);
    put(1'b0, 2, 1'b0, 32'h7200_0002);
    look("R4 partial mask", 1'b0, 1'b1, 1'b0, 32'hC80C_1234);
    check("R4 partial mask value", {3'b111, 32'h720C_1234});
  endtask

  task automatic t_perm;
    put(1'b0, 1, 1'b1, 32'h3000_1FFF);
    put(1'b0, 1, 1'b0, 32'h5000_0000);
    look("R5 no access", 1'b0, 1'b1, 1'b0, 32'h3000_0040);
    check("R5 no access hit", {3'b100, 32'h5000_0040});
    put(1'b0, 1, 1'b0, 32'h5000_0003);
    look("R5 both bits rw", 1'b0, 1'b1, 1'b0, 32'h3000_0040);
    put(1'b0, 1, 1'b0, 32'h5000_0001);
    look("R5 read only", 1'b0, 1'b1, 1'b0, 32'h3000_0040);
  endtask

  task automatic t_prio;
    put(1'b0, 3, 1'b1, 32'hC800_001F);
    put(1'b0, 3, 1'b0, 32'h9000_0001);
    look("R6 lower index wins", 1'b0, 1'b1, 1'b0, 32'hC80C_1234);
    check("R6 lower index value", {3'b111, 32'h720C_1234});
    put(1'b0, 2, 1'b1, 32'h0000_0000);
    look("R6 next entry when first disabled", 1'b0, 1'b1, 1'b0, 32'hC80C_1234);
    check("R6 next entry value", {3'b110, 32'h900C_1234});
  endtask

  task automatic t_sides;
    look("R1 instr table empty", 1'b1, 1'b1, 1'b0, 32'h8001_F345);
    put(1'b1, 0, 1'b1, 32'h8000_0003);
    put(1'b1, 0, 1'b0, 32'hA000_0002);
    look("R1 instr table hit", 1'b1, 1'b1, 1'b0, 32'h8001_F345);
    check("R1 instr value", {3'b111, 32'hA001_F345});
    look("R1 data table unchanged", 1'b0, 1'b1, 1'b0, 32'h8001_F345);
    check("R1 data value", {3'b111, 32'h2461_F345});
  endtask

  task automatic t_passthru;
    look("R7 data off", 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    check("R7 data off value", {3'b111, 32'hDEAD_B000});
    look("R7 instr off", 1'b1, 1'b0, 1'b0, 32'h8001_F345);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin
        m_hi[s][e] = '0;
        m_lo[s][e] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_timing();
    t_match();
    t_priv();
    t_partial();
    t_perm();
    t_prio();
    t_sides();
    t_passthru();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got running, expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule